// File: doc/BRIEF.md
# Power Button Sequencer

This block turns a single active-low push button into power-state requests. The raw button level is first synchronised and debounced. The debounced press is then timed against a slow timebase tick and classified. A press is momentary if it is released before the long threshold. It is long if it is still held when the threshold is reached. The press class and the current power state (off, running, asleep) together select one request: boot, power-down, enter-sleep or wake. The block then moves its own state to match.

Every request is a single-cycle pulse. The current state is always visible as an encoded output. A long action fires while the button is still down, so the operator gets feedback without letting go. The release that follows a long action is swallowed. Power-down drives only its own request line and asserts no reset of any kind.

The block carries no data stream, so it has no valid/ready interface and no back-pressure. The request pulses are fire-and-forget, and a consumer must capture them in the cycle they appear.

Top module: `pwr_button_seq`

## Requirements
- R1: After reset the state output reads OFF (encoding OFF=0, RUN=1, SLEEP=2, value 3 never appears) and no request line is high.
- R2: A momentary press while OFF raises `req_boot` for exactly one cycle, and in that same cycle the state reads RUN.
- R3: A momentary press while RUN raises `req_sleep` for one cycle, and the state becomes SLEEP.
- R4: A momentary press while SLEEP raises `req_wake` for one cycle, and the state becomes RUN.
- R5: A press held for LONG_TICKS ticks while RUN or SLEEP raises `req_pdown` for one cycle while the button is still held, and the state becomes OFF. No other request line rises.
- R6: The release that ends a press whose long action has fired produces no request.
- R7: A long press while OFF produces no request, neither at the threshold nor at release, and the state stays OFF.
- R8: A button level that holds for fewer than DB_CYCLES consecutive clock samples is ignored and produces no request.
- R9: At most one request line is high in any cycle, and the state changes only in a cycle in which a request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide, used to time press length |
| btn_n | input | 1 | Raw button level, low while pressed, asynchronous |
| req_boot | output | 1 | One-cycle boot request |
| req_pdown | output | 1 | One-cycle power-down request |
| req_sleep | output | 1 | One-cycle enter-sleep request |
| req_wake | output | 1 | One-cycle wake request |
| pwr_state | output | 2 | Current state: 0 OFF, 1 RUN, 2 SLEEP |

## Verification
The assertions run on every cycle. They check that requests are mutually exclusive, that the state never takes the unused code, and that each request pulse coincides with the correct from-state and to-state pair. They also check that the state never moves without a request. Other behaviours depend on how the button was driven over many cycles, so only the bench scenarios can show them. These are the glitch rejection, the swallowed release after a long action, the ignored long press while off, and the power-down firing before release. The bench covers them by comparing the stream of request pulses with a queue of expected ones.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_RUN   = 2'd1,
    PS_SLEEP = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pbs_debounce.sv
module pbs_debounce #(
  parameter int DB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic pressed
);
  localparam int CW = $clog2(DB_CYCLES + 1);

  logic       sync1, sync2;
  logic       stable_n;
  logic [CW-1:0] cnt;

  // two-flop synchroniser, idle level is released (high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= raw_n;
      sync2 <= sync1;
    end
  end

  // accept a new level only after DB_CYCLES consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_n <= 1'b1;
      cnt      <= '0;
    end else if (sync2 != stable_n) begin
      if (cnt == CW'(DB_CYCLES - 1)) begin
        stable_n <= sync2;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign pressed = ~stable_n;
endmodule

// File: rtl/pbs_press_timer.sv
module pbs_press_timer #(
  parameter int LONG_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pressed,
  input  logic tick,
  output logic short_evt,
  output logic long_evt
);
  localparam int TW = $clog2(LONG_TICKS + 1);

  logic          prev;
  logic          fired;
  logic [TW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      fired     <= 1'b0;
      hold_cnt  <= '0;
      short_evt <= 1'b0;
      long_evt  <= 1'b0;
    end else begin
      prev      <= pressed;
      short_evt <= 1'b0;
      long_evt  <= 1'b0;
      if (pressed && !prev) begin
        hold_cnt <= '0;
        fired    <= 1'b0;
      end else if (pressed && tick && !fired) begin
        if (hold_cnt == TW'(LONG_TICKS - 1)) begin
          long_evt <= 1'b1;
          fired    <= 1'b1;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else if (!pressed && prev) begin
        // release after a long action is swallowed
        short_evt <= ~fired;
      end
    end
  end
endmodule

// File: rtl/pbs_state_fsm.sv
module pbs_state_fsm
  import pbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       short_evt,
  input  logic       long_evt,
  output logic       req_boot,
  output logic       req_pdown,
  output logic       req_sleep,
  output logic       req_wake,
  output pwr_state_e state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_OFF;
      req_boot  <= 1'b0;
      req_pdown <= 1'b0;
      req_sleep <= 1'b0;
      req_wake  <= 1'b0;
    end else begin
      req_boot  <= 1'b0;
      req_pdown <= 1'b0;
      req_sleep <= 1'b0;
      req_wake  <= 1'b0;
      unique case (state)
        PS_OFF: begin
          if (short_evt) begin
            req_boot <= 1'b1;
            state    <= PS_RUN;
          end
        end
        PS_RUN: begin
          if (long_evt) begin
            req_pdown <= 1'b1;
            state     <= PS_OFF;
          end else if (short_evt) begin
            req_sleep <= 1'b1;
            state     <= PS_SLEEP;
          end
        end
        PS_SLEEP: begin
          if (long_evt) begin
            req_pdown <= 1'b1;
            state     <= PS_OFF;
          end else if (short_evt) begin
            req_wake <= 1'b1;
            state    <= PS_RUN;
          end
        end
        default: state <= PS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/pwr_button_seq.sv
module pwr_button_seq
  import pbs_pkg::*;
#(
  parameter int DB_CYCLES  = 4,
  parameter int LONG_TICKS = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_n,
  output logic       req_boot,
  output logic       req_pdown,
  output logic       req_sleep,
  output logic       req_wake,
  output logic [1:0] pwr_state
);
  logic       pressed;
  logic       short_evt;
  logic       long_evt;
  pwr_state_e state;

  pbs_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
    .clk(clk), .rst_n(rst_n), .raw_n(btn_n), .pressed(pressed)
  );

  pbs_press_timer #(.LONG_TICKS(LONG_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .pressed(pressed), .tick(tick),
    .short_evt(short_evt), .long_evt(long_evt)
  );

  pbs_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .short_evt(short_evt), .long_evt(long_evt),
    .req_boot(req_boot), .req_pdown(req_pdown),
    .req_sleep(req_sleep), .req_wake(req_wake), .state(state)
  );

  assign pwr_state = state;
endmodule

// File: rtl/pwr_button_seq_chk.sv
module pwr_button_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_boot,
  input logic       req_pdown,
  input logic       req_sleep,
  input logic       req_wake,
  input logic [1:0] pwr_state
);
  logic [3:0] reqs;
  assign reqs = {req_boot, req_pdown, req_sleep, req_wake};

  // R9 exclusive requests
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));
  // R1 legal encoding
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);
  // R2 boot leaves OFF for RUN
  a_r2_boot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_boot |-> (pwr_state == 2'd1 && $past(pwr_state) == 2'd0));
  // R3 sleep leaves RUN for SLEEP
  a_r3_sleep_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_sleep |-> (pwr_state == 2'd2 && $past(pwr_state) == 2'd1));
  // R4 wake leaves SLEEP for RUN
  a_r4_wake_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_wake |-> (pwr_state == 2'd1 && $past(pwr_state) == 2'd2));
  // R5 power-down reaches OFF from RUN or SLEEP
  a_r5_pdown_edge: assert property (@(posedge clk) disable iff (!rst_n)
    req_pdown |-> (pwr_state == 2'd0 && $past(pwr_state) != 2'd0));
  // R9 state moves only with a request
  a_r9_move_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != $past(pwr_state)) |-> (reqs != 4'd0));
  // R2 pulses last one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reqs != 4'd0) |=> (reqs == 4'd0));
endmodule

bind pwr_button_seq pwr_button_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_boot(req_boot), .req_pdown(req_pdown),
  .req_sleep(req_sleep), .req_wake(req_wake), .pwr_state(pwr_state)
);

// File: tb/pwr_button_seq_tb.sv
module pwr_button_seq_tb;
  localparam int DBC = 4;
  localparam int LT  = 20;
  // request kind codes used by the scoreboard
  localparam logic [1:0] K_BOOT = 2'd0, K_PDOWN = 2'd1, K_SLEEP = 2'd2, K_WAKE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       btn_n = 1'b1;
  logic       req_boot, req_pdown, req_sleep, req_wake;
  logic [1:0] pwr_state;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_kind[$];
  logic [1:0] exp_state[$];
  logic [1:0] tcnt = '0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= tcnt + 1'b1;
    tick <= (tcnt == 2'd3);
  end

  pwr_button_seq #(.DB_CYCLES(DBC), .LONG_TICKS(LT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
    .req_boot(req_boot), .req_pdown(req_pdown), .req_sleep(req_sleep),
    .req_wake(req_wake), .pwr_state(pwr_state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected requests as pulses appear
  always @(negedge clk) begin
    if (rst_n && (req_boot | req_pdown | req_sleep | req_wake)) begin
      logic [1:0] k;
      k = req_boot ? K_BOOT : req_pdown ? K_PDOWN : req_sleep ? K_SLEEP : K_WAKE;
      if (exp_kind.size() == 0) begin
        check(1'b0, "R6/R7/R8 unexpected request", k, -1);
      end else begin
        logic [1:0] ek, es;
        ek = exp_kind.pop_front();
        es = exp_state.pop_front();
        check(k == ek, "R2-R5 request kind", k, ek);
        check(pwr_state == es, "R2-R5 state with request", pwr_state, es);
        check($countones({req_boot, req_pdown, req_sleep, req_wake}) == 1,
              "R9 one request", $countones({req_boot, req_pdown, req_sleep, req_wake}), 1);
        if (req_pdown) check(btn_n == 1'b0, "R5 pdown while held", btn_n, 0);
      end
    end
  end

  task automatic hold(input int n);
    @(posedge clk); #1 btn_n = 1'b0;
    repeat (n) @(posedge clk);
    #1 btn_n = 1'b1;
    repeat (40) @(posedge clk);
  endtask

  task automatic short_press(input logic [1:0] k, input logic [1:0] s);
    exp_kind.push_back(k); exp_state.push_back(s);
    hold(20);
  endtask

  task automatic long_press(input bit expect_pd);
    if (expect_pd) begin
      exp_kind.push_back(K_PDOWN); exp_state.push_back(2'd0);
    end
    hold(200);
  endtask

  task automatic expect_state(input logic [1:0] s, input string req);
    @(negedge clk);
    check(pwr_state == s, req, pwr_state, s);
    check(exp_kind.size() == 0, req, exp_kind.size(), 0);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwr_state == 2'd0, "R1 reset state", pwr_state, 0);
    check({req_boot, req_pdown, req_sleep, req_wake} == 4'd0, "R1 no request in reset",
          {req_boot, req_pdown, req_sleep, req_wake}, 0);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    expect_state(2'd0, "R1 idle after reset");

    long_press(1'b0);          expect_state(2'd0, "R7 long press while off");
    hold(2);                   expect_state(2'd0, "R8 glitch while off");
    short_press(K_BOOT, 2'd1); expect_state(2'd1, "R2 boot");
    hold(1);                   expect_state(2'd1, "R8 glitch while running");
    short_press(K_SLEEP, 2'd2);expect_state(2'd2, "R3 sleep");
    short_press(K_WAKE, 2'd1); expect_state(2'd1, "R4 wake");
    long_press(1'b1);          expect_state(2'd0, "R5 R6 pdown from run");
    short_press(K_BOOT, 2'd1); expect_state(2'd1, "R2 boot again");
    short_press(K_SLEEP, 2'd2);expect_state(2'd2, "R3 sleep again");
    long_press(1'b1);          expect_state(2'd0, "R5 R6 pdown from sleep");
    // glitch released high during a hold: a 2-cycle bounce must not split the press
    @(posedge clk); #1 btn_n = 1'b0;
    repeat (10) @(posedge clk); #1 btn_n = 1'b1;
    repeat (2) @(posedge clk);  #1 btn_n = 1'b0;
    exp_kind.push_back(K_BOOT); exp_state.push_back(2'd1);
    repeat (10) @(posedge clk); #1 btn_n = 1'b1;
    repeat (40) @(posedge clk);
    expect_state(2'd1, "R8 bounce inside press");
    finish_run();
  end
endmodule